// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block derives a reference clock from one of sixteen parent clock sources. The parents arrive as single-cycle tick strobes in the system clock domain, one strobe per parent cycle. The selected parent is divided by twice a mixed number N + M/512. N is a 15-bit integer half-period length and M is a 9-bit trim. A trim accumulator spreads the fraction by stretching individual half periods by one parent cycle.

Software reaches a small register set through a write-enable, address and data port, with reads returned combinationally. The registers are a control word, a trim word and a key address. Every write to the control or trim word must be preceded by a two-word key sequence.

New N and M values wait in pending fields. A self-clearing switch request adopts both values together. This happens at an output falling edge while the divider runs, or at once while it is idle. An active flag reports whether the divider is running or still finishing a high half period.

Top module: `frac_refclk_div`

## Requirements
- R1: With N ≥ 1, half period j (counted from start, j = 1, 2, …) lasts N + floor(j·M/512) − floor((j−1)·M/512) ticks of the selected parent, so the output frequency is fin / (2·(N + M/512)).
- R2: With adopted N = 0 and the divider on, `ref_out` equals the selected parent tick delayed by one system clock.
- R3: With adopted M = 0 and N ≥ 1, each output period is exactly 2·N parent ticks.
- R4: Control bits 3:0 choose which `src_tick` bit is the parent. A write to that field is ignored while the active flag (control bit 8) reads 1.
- R5: Control bits 30:16 hold pending N and trim bits 31:23 hold pending M. Writing 1 to control bit 9 requests a switch. Both values are then adopted together at the next output falling edge, or at once when inactive. Bit 9 reads 1 until adoption and 0 after. Pending values have no effect without a switch.
- R6: Control bit 15 runs the divider. Control bit 12 gates the divided level onto `ref_out`; with it clear, `ref_out` stays 0 while the divider keeps running.
- R7: The active flag reads 1 from the moment bit 15 is set. Clearing bit 15 during a high half lets that half finish at its full length. The output then stops low and the active flag reads 0.
- R8: A control or trim write takes effect only if it directly follows a write of 0xC3A5_9D17 and then 0x5E6B_0F42 to address 2. Otherwise it is ignored. Address 0 is control and address 1 is trim.
- R9: After reset, control and trim read 0 and `ref_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 16 | One tick strobe per parent clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 trim, 2 key) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| ref_out | output | 1 | Reference clock output |

## Verification
On every cycle the assertions check several invariants. Parent selection never changes while active. Adopted N and M change only under a pending switch request. An idle, stopped divider keeps its level low. The half-period counter never exceeds N. Locked writes leave all writable fields untouched.

Some behaviours can only be shown by the bench scenarios. These are the exact period lengths under random N, M and parent rates, and the one-cycle passthrough. They also include the moment a switch takes hold, and the full-length final high half when the divider is turned off.

// File: rtl/frac_refclk_div.sv
module frac_refclk_div #(
  parameter int NSRC = 16,
  parameter int SELW = 4,
  parameter int NW = 15,
  parameter int MW = 9,
  parameter logic [31:0] KEY_A = 32'hC3A5_9D17,
  parameter logic [31:0] KEY_B = 32'h5E6B_0F42
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            ref_out
);
  localparam int CW = NW + 1;
  localparam int SEL_LSB = 0;
  localparam int ACT_BIT = 8;
  localparam int SW_BIT = 9;
  localparam int OE_BIT = 12;
  localparam int EN_BIT = 15;
  localparam int N_LSB = 16;
  localparam int M_LSB = 23;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TRIM = 2'd1;
  localparam logic [1:0] A_KEY = 2'd2;

  logic [SELW-1:0] sel_q;
  logic            en_q, oe_q, sw_q, lvl_q;
  logic [NW-1:0]   pend_n, n_cur;
  logic [MW-1:0]   pend_m, m_cur, acc_q;
  logic [CW-1:0]   cnt_q;
  logic [1:0]      ust_q;

  logic          unlocked, wr_ctrl, wr_trim;
  logic          tick_sel, active, bypass, div_toggle, fall_evt, load, lvl_nxt;
  logic [MW:0]   sum;
  logic [CW-1:0] len;

  assign unlocked = (ust_q == 2'd2);
  assign wr_ctrl  = wr_en && addr == A_CTRL && unlocked;
  assign wr_trim  = wr_en && addr == A_TRIM && unlocked;
  assign tick_sel = src_tick[sel_q];
  assign active   = en_q | lvl_q;
  assign bypass   = (n_cur == '0);
  assign sum      = {1'b0, acc_q} + {1'b0, m_cur};
  assign len      = CW'(n_cur) + CW'(sum[MW]);
  assign div_toggle = tick_sel && !bypass && active && ((cnt_q + CW'(1)) >= len);
  assign lvl_nxt  = bypass ? (en_q & tick_sel) : (div_toggle ? ~lvl_q : lvl_q);
  assign fall_evt = lvl_q && !lvl_nxt;
  assign load     = sw_q && (!active || fall_evt);
  assign ref_out  = lvl_q & oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ust_q <= 2'd0;
    else if (wr_en) begin
      if (addr == A_KEY) begin
        if (wr_data == KEY_A) ust_q <= 2'd1;
        else if (ust_q == 2'd1 && wr_data == KEY_B) ust_q <= 2'd2;
        else ust_q <= 2'd0;
      end else ust_q <= 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; en_q <= 1'b0; oe_q <= 1'b0; pend_n <= '0; pend_m <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data[EN_BIT];
        oe_q   <= wr_data[OE_BIT];
        pend_n <= wr_data[N_LSB +: NW];
        if (!active) sel_q <= wr_data[SEL_LSB +: SELW];
      end
      if (wr_trim) pend_m <= wr_data[M_LSB +: MW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else if (wr_ctrl && wr_data[SW_BIT]) sw_q <= 1'b1;
    else if (load) sw_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cur <= '0; m_cur <= '0; acc_q <= '0; cnt_q <= '0; lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt;
      if (load) begin
        n_cur <= pend_n;
        m_cur <= pend_m;
        acc_q <= '0;
        cnt_q <= '0;
      end else if (!active || bypass) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (tick_sel) begin
        if (div_toggle) begin
          cnt_q <= '0;
          acc_q <= sum[MW-1:0];
        end else cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: begin
        rd_data[SEL_LSB +: SELW] = sel_q;
        rd_data[ACT_BIT]         = active;
        rd_data[SW_BIT]          = sw_q;
        rd_data[OE_BIT]          = oe_q;
        rd_data[EN_BIT]          = en_q;
        rd_data[N_LSB +: NW]     = pend_n;
      end
      A_TRIM: rd_data[M_LSB +: MW] = pend_m;
      default: ;
    endcase
  end

  a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> !$past(active));

  a_r5_paired_adopt: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_cur != $past(n_cur)) || (m_cur != $past(m_cur))) |-> $past(sw_q));

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !lvl_q) |=> !lvl_q);

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bypass) |-> (cnt_q <= CW'(n_cur)));

  a_r8_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_KEY && ust_q != 2'd2) |=>
      ($stable(pend_n) && $stable(pend_m) && $stable(en_q) && $stable(oe_q)));
endmodule

// File: tb/sim_frac_refclk_div.sv
`timescale 1ns/1ps
module sim_frac_refclk_div;
  localparam logic [31:0] KA = 32'hC3A5_9D17;
  localparam logic [31:0] KB = 32'h5E6B_0F42;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] src_tick = '0;
  logic [1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic ref_out;
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frac_refclk_div u0 (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .ref_out(ref_out));

  function automatic int per(int i); return 1 + (i % 4); endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 16; i++) src_tick[i] <= (((cyc + 1) % per(i)) == 0);
  end

  function automatic int exp_cycles(int n, int m, int p, int k);
    int t = 0;
    for (int j = 2; j <= 2*k + 1; j++) t += n + (j*m)/512 - ((j-1)*m)/512;
    return t * p;
  endfunction

  function automatic logic [31:0] ctrl_w(int n, bit en, bit oe, bit sw, int sel);
    return (32'(n) << 16) | (32'(en) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel & 15);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic uwr(logic [1:0] a, logic [31:0] d);
    wr(2'd2, KA); wr(2'd2, KB); wr(a, d);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rd_data;
  endtask

  task automatic wait_rise(output int n);
    logic prev = ref_out;
    n = 0;
    while (1) begin
      @(negedge clk); n++;
      if (ref_out && !prev) break;
      prev = ref_out;
      if (n > 20000) break;
    end
  endtask

  task automatic meas(int k, output int tot);
    int n;
    wait_rise(n);
    tot = 0;
    for (int i = 0; i < k; i++) begin wait_rise(n); tot += n; end
  endtask

  task automatic stop_idle();
    logic [31:0] v;
    uwr(2'd0, ctrl_w(0, 0, 1, 0, 0));
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if (!v[8]) break;
    end
  endtask

  task automatic start(int n, int m, int sel);
    stop_idle();
    uwr(2'd1, 32'(m) << 23);
    uwr(2'd0, ctrl_w(n, 0, 1, 1, sel));
    uwr(2'd0, ctrl_w(n, 1, 1, 0, sel));
  endtask

  initial begin
    while (!done) begin
      @(negedge clk);
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int tot, n, m, s, t0, seed;
    bit ok;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk(v == 0, "R9 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R9 trim", v, 0);
    chk(ref_out == 0, "R9 ref_out", ref_out, 0);

    wr(2'd0, ctrl_w(3, 1, 1, 1, 2));
    rd(2'd0, v); chk(v == 0, "R8 no key", v, 0);
    wr(2'd2, KA); wr(2'd2, 32'h1111_2222); wr(2'd1, 32'hFF80_0000);
    rd(2'd1, v); chk(v == 0, "R8 bad key", v, 0);
    wr(2'd2, KA); wr(2'd2, KB); wr(2'd1, 32'(5) << 23); wr(2'd1, 32'(9) << 23);
    rd(2'd1, v); chk(v == (32'(5) << 23), "R8 single use", v, 32'(5) << 23);

    start(3, 0, 0); meas(4, tot);
    chk(tot == 24, "R3 N=3 P=1", tot, 24);
    start(5, 0, 2); meas(4, tot);
    chk(tot == 120, "R3 N=5 P=3", tot, 120);

    start(0, 0, 1);
    repeat (4) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_out !== src_tick[1]) ok = 0;
    end
    chk(ok, "R2 passthrough sel1", ok, 1);
    start(0, 0, 3);
    repeat (4) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ref_out !== src_tick[3]) ok = 0;
    end
    chk(ok, "R2 passthrough sel3", ok, 1);

    start(2, 0, 0);
    uwr(2'd0, ctrl_w(2, 1, 0, 0, 0));
    ok = 1;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ref_out) ok = 0; end
    chk(ok, "R6 oe low keeps output low", ok, 1);
    rd(2'd0, v); chk(v[8] == 1, "R6 still active", v[8], 1);
    uwr(2'd0, ctrl_w(2, 1, 1, 0, 0)); meas(3, tot);
    chk(tot == 12, "R6 oe restored", tot, 12);

    chk(1, "R1 seed", seed, seed);
    for (int it = 0; it < 14; it++) begin
      if (it == 0) begin n = 1; m = 511; s = 0; end
      else if (it == 1) begin n = 2; m = 256; s = 5; end
      else begin n = 1 + $urandom_range(11); m = $urandom_range(511); s = $urandom_range(15); end
      start(n, m, s); meas(6, tot);
      chk(tot == exp_cycles(n, m, per(s), 6), $sformatf("R1 N=%0d M=%0d sel=%0d", n, m, s),
          tot, exp_cycles(n, m, per(s), 6));
    end

    start(4, 0, 0);
    uwr(2'd0, ctrl_w(9, 1, 1, 0, 0)); meas(3, tot);
    chk(tot == 24, "R5 pending ignored", tot, 24);
    uwr(2'd1, 32'(100) << 23); meas(3, tot);
    chk(tot == 24, "R5 pending M ignored", tot, 24);
    uwr(2'd1, 32'(0));
    uwr(2'd0, ctrl_w(7, 1, 1, 1, 0));
    rd(2'd0, v); chk(v[9] == 1, "R5 switch pending", v[9], 1);
    for (int i = 0; i < 200; i++) begin rd(2'd0, v); if (!v[9]) break; end
    chk(v[9] == 0, "R5 switch self-clear", v[9], 0);
    chk(v[30:16] == 7, "R5 pending N field", v[30:16], 7);
    meas(3, tot); chk(tot == 42, "R5 new N adopted", tot, 42);

    uwr(2'd0, ctrl_w(7, 1, 1, 0, 3));
    rd(2'd0, v); chk(v[3:0] == 0, "R4 sel write ignored", v[3:0], 0);
    meas(3, tot); chk(tot == 42, "R4 parent unchanged", tot, 42);

    start(40, 0, 0);
    rd(2'd0, v); chk(v[8] == 1, "R7 active on enable", v[8], 1);
    wait_rise(n); t0 = cyc;
    uwr(2'd0, ctrl_w(40, 0, 1, 0, 0));
    rd(2'd0, v); chk(v[8] == 1 && ref_out == 1, "R7 active during last high", v[8], 1);
    while (ref_out && (cyc - t0) < 1000) @(negedge clk);
    chk((cyc - t0) == 40, "R7 last high full length", cyc - t0, 40);
    rd(2'd0, v); chk(v[8] == 0, "R7 inactive after stop", v[8], 0);
    ok = 1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (ref_out) ok = 0; end
    chk(ok, "R7 stays low", ok, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule